// File: doc/BRIEF.md
# Alternating-Polarity Line Test Pulse Generator

This block produces the symbol stream for two line test signals. Each symbol is one of three ternary levels: positive mark, negative mark or zero. A line encoder downstream turns each symbol into a pulse. A single-cycle enable marks each bit period of the line, and the output symbol is updated only on those enables. A host picks the test pattern through a two-bit mode input.

In isolated mode, one mark is sent and is followed by zero level until the next mark, 250 µs later. Marks alternate in sign, so a full positive-and-negative pair repeats at 2 kHz. In continuous mode, a mark is sent in every bit period with alternating sign. At the nominal 192 kbit/s this gives a 96 kHz fundamental. When no test mode is selected, the line sits at zero. A newly selected pattern always begins with a positive mark.

The bit rate and the pair rate are parameters. The spacing in bit periods is derived from them, and is 48 at the defaults.

Top module: `altpulse_gen`

## Requirements
- R1: After a synchronous reset the output symbol is zero and no mode is applied, so the first tick with an active mode emits a positive mark.
- R2: The symbol code is 2'b00 for zero, 2'b01 for a positive mark and 2'b10 for a negative mark. The code 2'b11 never appears.
- R3: The output changes only on a clock edge at which `bit_tick` is high. It holds its value through the clock cycles between ticks, whatever `mode_sel` does during them.
- R4: Mode code 2'b00 (and the unused code 2'b11) selects no test pattern. A tick with such a code drives the output to zero.
- R5: On a tick where an active mode code differs from the mode applied at the previous tick, the output becomes a positive mark on that tick.
- R6: Mode code 2'b10 (continuous) emits a mark on every tick, and each mark has the opposite sign of the one before.
- R7: Mode code 2'b01 (isolated) emits a mark one tick wide, then zero for SPACING-1 ticks. The next mark comes exactly SPACING ticks after the previous one (48 at defaults).
- R8: In isolated mode, successive marks alternate in sign, starting positive.
- R9: A direct switch between the isolated and continuous modes restarts the pattern on the switching tick. A positive mark is sent, and in isolated mode the spacing is counted from that mark.
- R10: Leaving the test modes for idle and then reselecting a mode starts again with a positive mark. The sign of the last mark before idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable, once per line bit period |
| mode_sel | input | 2 | Test pattern select: 00 idle, 01 isolated, 10 continuous, 11 idle |
| sym_out | output | 2 | Ternary symbol: 00 zero, 01 positive, 10 negative |

## Verification
A corrupted spacing counter would move the next isolated mark earlier or later, or make it vanish. That error shows within one spacing period, at most 48 ticks. A wrong sign register shows as two marks of the same sign in a row. In continuous mode that is visible on the very next tick, and in isolated mode at the next mark. A stale applied-mode register shows at the first tick after a mode change: the positive restart mark is missing, or a mark arrives while idle is selected.

// File: rtl/altpulse_pkg.sv
package altpulse_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10
    } sym_t;

    typedef enum logic [1:0] {
        TM_IDLE   = 2'b00,
        TM_SINGLE = 2'b01,
        TM_CONT   = 2'b10
    } tmode_t;

    // Raw host code to applied mode; the spare code folds to idle.
    function automatic tmode_t decode_mode(input logic [1:0] raw);
        tmode_t m;
        case (raw)
            2'b01:   m = TM_SINGLE;
            2'b10:   m = TM_CONT;
            default: m = TM_IDLE;
        endcase
        return m;
    endfunction

    function automatic sym_t opposite(input sym_t s);
        return (s == SYM_POS) ? SYM_NEG : SYM_POS;
    endfunction

endpackage

// File: rtl/altpulse_space_cnt.sv
module altpulse_space_cnt
    import altpulse_pkg::*;
#(
    parameter int SPACING = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic due
);
    localparam int CNT_W = (SPACING > 2) ? $clog2(SPACING) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SPACING - 1);

    // Ticks elapsed since the last mark, minus one.
    logic [CNT_W-1:0] cnt_q;

    assign due = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (restart || due) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && restart) |=> (cnt_q == '0));

endmodule

// File: rtl/altpulse_polarity.sv
module altpulse_polarity
    import altpulse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic advance,
    output sym_t mark_sym
);
    // Sign of the most recent mark sent.
    sym_t last_q;

    assign mark_sym = load ? SYM_POS : opposite(last_q);

    always_ff @(posedge clk) begin
        if (rst)                  last_q <= SYM_NEG;
        else if (load || advance) last_q <= mark_sym;
    end

    assert_sign_flips_R8: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (last_q != $past(last_q)));

endmodule

// File: rtl/altpulse_gen.sv
module altpulse_gen
    import altpulse_pkg::*;
#(
    parameter int BIT_RATE_HZ  = 192000,
    parameter int PAIR_RATE_HZ = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic [1:0] mode_sel,
    output logic [1:0] sym_out
);
    // Ticks from one isolated mark to the next.
    localparam int SPACING = BIT_RATE_HZ / (2 * PAIR_RATE_HZ);

    tmode_t req_mode;
    tmode_t cur_q;
    sym_t   sym_q;
    sym_t   mark_sym;
    logic   start;
    logic   fire;
    logic   due;

    assign req_mode = decode_mode(mode_sel);

    // A fresh active selection restarts the pattern.
    assign start = bit_tick && (req_mode != cur_q) && (req_mode != TM_IDLE);

    // An unchanged active mode emits its next mark.
    assign fire  = bit_tick && (req_mode == cur_q) &&
                   ((cur_q == TM_CONT) || ((cur_q == TM_SINGLE) && due));

    altpulse_space_cnt #(.SPACING(SPACING)) u_space (
        .clk     (clk),
        .rst     (rst),
        .tick    (bit_tick),
        .restart (start),
        .due     (due)
    );

    altpulse_polarity u_pol (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .advance  (fire),
        .mark_sym (mark_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= TM_IDLE;
            sym_q <= SYM_ZERO;
        end else if (bit_tick) begin
            cur_q <= req_mode;
            sym_q <= (start || fire) ? mark_sym : SYM_ZERO;
        end
    end

    assign sym_out = sym_q;

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (rst)
        sym_out != 2'b11);

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(bit_tick) && !$past(rst)) |-> $stable(sym_out));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && (req_mode == TM_IDLE)) |=> (sym_out == SYM_ZERO));

    assert_start_pos_R5: assert property (@(posedge clk) disable iff (rst)
        start |=> (sym_out == SYM_POS));

    assert_cont_alt_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && (cur_q == TM_CONT) && (req_mode == TM_CONT))
        |=> (sym_out == opposite($past(sym_q))));

    assert_single_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && (cur_q == TM_SINGLE) && (req_mode == TM_SINGLE) && (sym_q != SYM_ZERO))
        |=> (sym_out == SYM_ZERO));

endmodule

// File: tb/sim_altpulse_gen.sv
module sim_altpulse_gen;

    localparam int SP = 48;
    localparam logic [1:0] Z = 2'b00;
    localparam logic [1:0] P = 2'b01;
    localparam logic [1:0] N = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] sym_out;

    int checks = 0;
    int errors = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] last_exp = 2'b00;
    logic       tick_prev = 1'b0;

    // Reference state: applied mode, ticks since last mark, last mark sign.
    int         r_mode  = 0;
    int         r_since = 0;
    logic [1:0] r_last  = Z;

    altpulse_gen u0 (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .mode_sel (mode_sel),
        .sym_out  (sym_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) tick_prev <= bit_tick;

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] model(input int raw);
        int m;
        logic [1:0] e;
        m = (raw == 1 || raw == 2) ? raw : 0;
        e = Z;
        if (m != r_mode) begin
            r_mode = m;
            if (m != 0) begin
                e = P; r_last = P; r_since = 0;
            end
        end else if (m == 2) begin
            e = (r_last == P) ? N : P;
            r_last = e;
        end else if (m == 1) begin
            r_since++;
            if (r_since == SP) begin
                e = (r_last == P) ? N : P;
                r_last = e;
                r_since = 0;
            end
        end
        return e;
    endfunction

    // Driver: one tick with the given mode, expected symbol queued.
    task automatic tick(input int m, input string tag);
        @(negedge clk);
        mode_sel = 2'(m);
        bit_tick = 1'b1;
        exp_q.push_back(model(m));
        tag_q.push_back(tag);
        @(negedge clk);
        bit_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare after each tick edge, check hold otherwise.
    always @(negedge clk) begin
        if (rst) begin
            last_exp = Z;
        end else if (tick_prev) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard actual=empty expected=item");
            end else begin
                last_exp = exp_q.pop_front();
                check({tag_q.pop_front(), " R2"}, sym_out, last_exp);
            end
        end else begin
            check("R3 hold", sym_out, last_exp);
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", sym_out, Z);

        repeat (4) tick(0, "R4 idle");
        repeat (3) tick(3, "R4 spare");

        tick(1, "R5 first");
        repeat (SP * 3 + 5) tick(1, "R7 R8 single");

        // Mode change without a tick must not move the output.
        @(negedge clk); mode_sel = 2'b10;
        repeat (3) @(negedge clk);

        tick(2, "R9 to cont");
        repeat (9) tick(2, "R6 cont");

        tick(1, "R9 to single");
        repeat (SP + 3) tick(1, "R9 spacing");

        repeat (3) tick(0, "R10 idle");
        tick(1, "R10 reselect");
        repeat (4) tick(1, "R7 gap");

        // Reset in mid-pattern.
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        r_mode = 0; r_since = 0; r_last = Z;
        @(negedge clk);
        check("R1 mid reset", sym_out, Z);
        tick(1, "R1 restart");
        tick(2, "R9 back to cont");
        tick(2, "R6 cont");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule